// File: doc/BRIEF.md
# Region Histogram Engine

The engine collects intensity histograms from a raw pixel stream. Each valid pixel arrives with its row and column coordinate. The first pixel of a frame carries a frame-start flag. The pixel is multiplied by one of four gain values, chosen from its colour phase, and the product saturates to 10 bits. A right shift then turns the scaled value into a bin index. Up to four rectangular regions of interest are checked against the pixel's coordinate. For every region that contains the pixel, the engine increments one counter in a shared bin memory.

Software programs the mode, the gains, the region bounds, the bin count and the enable through a small write-only register port. Written values are held in shadow registers, and all of them take effect together on the next frame-start pixel. The bin memory is updated through a three-stage read-modify-write pipeline. Forwarding in that pipeline makes every hit count, including back-to-back hits on the same counter. A read port returns any counter combinationally for inspection.

Top module: `hist_engine`

## Requirements
- R1: After reset every bin counter reads 0 and `busy_o` is low.
- R2: The region count is the control field at bits [5:4] plus one. Only regions below that count are tested. Region r has an inclusive column window: start at bits [9:0] and end at bits [25:16] of register 2+2r. Its inclusive row window uses the same bit positions in register 3+2r. A pixel inside several regions increments one bin in each of them.
- R3: The control field at bits [3:2] selects 32, 64, 128 or 256 bins for codes 0 to 3. The bin index is the scaled 10-bit value shifted right by (10 - log2 bins).
- R4: The effective bin count is clamped to at most 256 with one region, 128 with two regions and 64 with three or four regions.
- R5: Region r, with B effective bins, owns the contiguous words r*B to r*B+B-1, and bin k of region r is word r*B+k.
- R6: Register 1 holds gain k in byte k, as unsigned 3.5 fixed point. In Bayer mode (control bit 1 = 0) the gain index is 2*row[0] + col[0]. The scaled value is min(1023, (pixel*gain) >> 5).
- R7: In three-channel mode (control bit 1 = 1) the gain index is col mod 3, so gain 3 is never applied.
- R8: Consecutive pixels that hit the same bin are all counted; none are lost in the pipeline.
- R9: A counter that reaches its maximum value stays there and does not wrap.
- R10: Register writes (control at address 0) take effect only at a valid pixel that carries the frame-start flag. A frame start that applies an enabled configuration clears all bins.
- R11: With the enable (control bit 0) low, pixels change no counter and a frame start leaves the bins untouched. `busy_o` takes the applied enable value at each frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| pix_valid_i | input | 1 | Pixel valid |
| pix_sof_i | input | 1 | Frame start, qualified by pix_valid_i |
| pix_row_i | input | 10 | Pixel row coordinate |
| pix_col_i | input | 10 | Pixel column coordinate |
| pix_data_i | input | 10 | Raw pixel value |
| bin_raddr_i | input | 8 | Bin memory read address |
| bin_rdata_o | output | CNT_W | Bin counter at bin_raddr_i |
| busy_o | output | 1 | Frame statistics collection active |

## Verification
Bursts of identical pixels stress the forwarding path. A design that lost the bypass would undercount those bins. Four fully overlapping regions with a 256-bin request show whether the 64-bin clamp and the per-region slice addressing are right. Without the clamp, the region slices would overlap and counts would spill into a neighbouring region.

A configuration written in the middle of a frame must leave the remaining pixels of that frame unchanged. A design that applied it at once would bin those pixels with the new gains. Long runs into one bin reach the counter ceiling, where a wrapping counter would fall back to small values. A disabled frame start must keep the old results, which a design that cleared on every frame start would lose.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int PIX_W      = 10;
  localparam int COORD_W    = 10;
  localparam int GAIN_W     = 8;
  localparam int GAIN_FRAC  = 5;
  localparam int NREG       = 4;
  localparam int MIN_BIN_LG = 5;   // 32 bins
  localparam int BIN_AW     = 8;   // 256 words total
  localparam int PROD_W     = PIX_W + GAIN_W;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_GAIN = 4'd1;
  localparam int         A_REG0 = 2;

  typedef struct packed {
    logic [COORD_W-1:0] h_lo;
    logic [COORD_W-1:0] h_hi;
    logic [COORD_W-1:0] v_lo;
    logic [COORD_W-1:0] v_hi;
  } roi_t;

  typedef struct packed {
    logic                         en;
    logic                         tri_mode;
    logic [1:0]                   bins_code;
    logic [1:0]                   nreg_m1;
    logic [3:0][GAIN_W-1:0]       gain;
    roi_t [NREG-1:0]              roi;
  } hist_cfg_t;
endpackage

// File: rtl/hist_cfg_regs.sv
module hist_cfg_regs
  import hist_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [3:0]  cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        apply_i,
  output hist_cfg_t   cfg_o
);
  hist_cfg_t shadow_q, active_q;
  logic      unused_wdata;

  assign unused_wdata = ^{cfg_wdata_i[31:26], cfg_wdata_i[15:10]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (apply_i) active_q <= shadow_q;
      if (cfg_we_i) begin
        if (cfg_addr_i == A_CTRL) begin
          shadow_q.en        <= cfg_wdata_i[0];
          shadow_q.tri_mode  <= cfg_wdata_i[1];
          shadow_q.bins_code <= cfg_wdata_i[3:2];
          shadow_q.nreg_m1   <= cfg_wdata_i[5:4];
        end
        if (cfg_addr_i == A_GAIN) shadow_q.gain <= cfg_wdata_i;
        for (int r = 0; r < NREG; r++) begin
          if (cfg_addr_i == 4'(A_REG0 + 2*r)) begin
            shadow_q.roi[r].h_lo <= cfg_wdata_i[COORD_W-1:0];
            shadow_q.roi[r].h_hi <= cfg_wdata_i[16 +: COORD_W];
          end
          if (cfg_addr_i == 4'(A_REG0 + 2*r + 1)) begin
            shadow_q.roi[r].v_lo <= cfg_wdata_i[COORD_W-1:0];
            shadow_q.roi[r].v_hi <= cfg_wdata_i[16 +: COORD_W];
          end
        end
      end
    end
  end

  // the frame-start pixel already sees the new settings
  assign cfg_o = apply_i ? shadow_q : active_q;

  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(active_q));
endmodule

// File: rtl/hist_pixel_map.sv
module hist_pixel_map
  import hist_pkg::*;
(
  input  hist_cfg_t                      cfg_i,
  input  logic [COORD_W-1:0]             row_i,
  input  logic [COORD_W-1:0]             col_i,
  input  logic [PIX_W-1:0]               data_i,
  output logic [NREG-1:0]                hit_o,
  output logic [NREG-1:0][BIN_AW-1:0]    addr_o,
  output logic [1:0]                     code_o
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [1:0]              lim, code, gsel;
  logic [PROD_W-1:0]       prod, scaled_full;
  logic [PIX_W-1:0]        scaled;
  logic [BIN_AW-1:0]       bin;

  always_comb begin
    unique case (cfg_i.nreg_m1)
      2'd0:    lim = 2'd3;
      2'd1:    lim = 2'd2;
      default: lim = 2'd1;
    endcase
    code = (cfg_i.bins_code > lim) ? lim : cfg_i.bins_code;
    gsel = cfg_i.tri_mode ? 2'(col_i % COORD_W'(3)) : {row_i[0], col_i[0]};
    prod = PROD_W'(data_i) * PROD_W'(cfg_i.gain[gsel]);
    scaled_full = prod >> GAIN_FRAC;
    scaled = (scaled_full > PROD_W'(PIX_MAX)) ? PIX_MAX : PIX_W'(scaled_full);
    bin = BIN_AW'(scaled >> (PIX_W - MIN_BIN_LG - int'(code)));
  end

  assign code_o = code;

  for (genvar r = 0; r < NREG; r++) begin : g_roi
    assign hit_o[r] = (2'(r) <= cfg_i.nreg_m1) &&
                      (col_i >= cfg_i.roi[r].h_lo) && (col_i <= cfg_i.roi[r].h_hi) &&
                      (row_i >= cfg_i.roi[r].v_lo) && (row_i <= cfg_i.roi[r].v_hi);
    assign addr_o[r] = (BIN_AW'(r) << (MIN_BIN_LG + int'(code))) | bin;
  end
endmodule

// File: rtl/hist_bin_mem.sv
module hist_bin_mem
  import hist_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic [NREG-1:0]               in_vld_i,
  input  logic [NREG-1:0][BIN_AW-1:0]   in_addr_i,
  input  logic [BIN_AW-1:0]             raddr_i,
  output logic [CNT_W-1:0]              rdata_o
);
  localparam int DEPTH = 1 << BIN_AW;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]              mem [DEPTH];
  logic [NREG-1:0]               s1_vld, s2_vld;
  logic [NREG-1:0][BIN_AW-1:0]   s1_addr, s2_addr;
  logic [NREG-1:0][CNT_W-1:0]    s2_data, nxt;

  // stage 1: read with bypass from the pending write, saturating increment
  for (genvar r = 0; r < NREG; r++) begin : g_rmw
    logic [CNT_W-1:0] cur;
    assign cur    = (s2_vld[r] && s2_addr[r] == s1_addr[r]) ? s2_data[r] : mem[s1_addr[r]];
    assign nxt[r] = (cur == CNT_MAX) ? cur : cur + CNT_W'(1);

    assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s2_vld[r] |-> s2_data[r] != '0);
    assert_fwd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s1_vld[r] && s2_vld[r] && s1_addr[r] == s2_addr[r] && !clear_i && s2_data[r] != CNT_MAX)
      |=> (s2_vld[r] && s2_data[r] == $past(s2_data[r]) + CNT_W'(1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= '0;
      s2_vld  <= '0;
      s1_addr <= '0;
      s2_addr <= '0;
      s2_data <= '0;
    end else begin
      s1_vld  <= in_vld_i;
      s1_addr <= in_addr_i;
      s2_vld  <= clear_i ? '0 : s1_vld;
      s2_addr <= s1_addr;
      s2_data <= nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      // region slices are disjoint, so writes never collide
      for (int r = 0; r < NREG; r++)
        if (s2_vld[r]) mem[s2_addr[r]] <= s2_data[r];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [3:0]           cfg_addr_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic                 pix_valid_i,
  input  logic                 pix_sof_i,
  input  logic [COORD_W-1:0]   pix_row_i,
  input  logic [COORD_W-1:0]   pix_col_i,
  input  logic [PIX_W-1:0]     pix_data_i,
  input  logic [BIN_AW-1:0]    bin_raddr_i,
  output logic [CNT_W-1:0]     bin_rdata_o,
  output logic                 busy_o
);
  hist_cfg_t                    cfg;
  logic                         sof_acc, clear, busy_q;
  logic [NREG-1:0]              hit, wr_vld;
  logic [NREG-1:0][BIN_AW-1:0]  addr;
  logic [1:0]                   code;

  assign sof_acc = pix_valid_i & pix_sof_i;

  hist_cfg_regs u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .apply_i (sof_acc),
    .cfg_o   (cfg)
  );

  hist_pixel_map u_map (
    .cfg_i  (cfg),
    .row_i  (pix_row_i),
    .col_i  (pix_col_i),
    .data_i (pix_data_i),
    .hit_o  (hit),
    .addr_o (addr),
    .code_o (code)
  );

  assign wr_vld = hit & {NREG{pix_valid_i & cfg.en}};
  assign clear  = sof_acc & cfg.en;

  hist_bin_mem #(.CNT_W(CNT_W)) u_mem (
    .clk_i, .rst_ni,
    .clear_i   (clear),
    .in_vld_i  (wr_vld),
    .in_addr_i (addr),
    .raddr_i   (bin_raddr_i),
    .rdata_o   (bin_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (sof_acc) busy_q <= cfg.en;
  end
  assign busy_o = busy_q;

  assert_busy_sof_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(busy_q) |-> $past(sof_acc));
  assert_bin_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && cfg.nreg_m1[1]) |-> code <= 2'd1);
  assert_unused_region_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |-> (hit >> (int'(cfg.nreg_m1) + 1)) == '0);
  for (genvar r = 0; r < NREG; r++) begin : g_chk
    assert_slice_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[r] |-> (addr[r] >> (MIN_BIN_LG + int'(code))) == BIN_AW'(r));
  end
endmodule

// File: tb/hist_engine_bench.sv
`timescale 1ns/1ps
module hist_engine_bench;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        pv = 0, psof = 0;
  logic [9:0]  prow = 0, pcol = 0, pdat = 0;
  logic [7:0]  raddr = 0;
  logic [CW-1:0] rdata;
  logic        busy;

  hist_engine #(.CNT_W(CW)) u_hist_engine (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .pix_valid_i(pv), .pix_sof_i(psof), .pix_row_i(prow), .pix_col_i(pcol), .pix_data_i(pdat),
    .bin_raddr_i(raddr), .bin_rdata_o(rdata), .busy_o(busy));

  int checks = 0, errors = 0;
  logic [31:0] sh [10];
  logic [31:0] act [10];
  int ref_m [256];
  int busy_exp = 0;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(int en, int tri_m, int code, int nm1);
    return 32'(en | (tri_m << 1) | (code << 2) | (nm1 << 4));
  endfunction

  task automatic wr(int a, logic [31:0] d);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d; sh[a] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic model(int sof, int row, int col, int dat);
    int nr, code, lim, gi, g, sc, bin, a;
    if (sof != 0) begin
      for (int i = 0; i < 10; i++) act[i] = sh[i];
      busy_exp = int'(act[0][0]);
      if (act[0][0]) for (int i = 0; i < 256; i++) ref_m[i] = 0;
    end
    if (!act[0][0]) return;
    nr = int'(act[0][5:4]) + 1;
    code = int'(act[0][3:2]);
    lim = (nr == 1) ? 3 : (nr == 2) ? 2 : 1;
    if (code > lim) code = lim;
    gi = act[0][1] ? (col % 3) : ((row % 2) * 2 + (col % 2));
    g = int'((act[1] >> (8 * gi)) & 32'hff);
    sc = (dat * g) / 32;
    if (sc > 1023) sc = 1023;
    bin = sc >> (5 - code);
    for (int r = 0; r < nr; r++) begin
      if (col >= int'(act[2+2*r][9:0]) && col <= int'(act[2+2*r][25:16]) &&
          row >= int'(act[3+2*r][9:0]) && row <= int'(act[3+2*r][25:16])) begin
        a = r * (32 << code) + bin;
        if (ref_m[a] < CMAX) ref_m[a]++;
      end
    end
  endtask

  task automatic pix(int sof, int row, int col, int dat);
    pv = 1; psof = (sof != 0); prow = 10'(row); pcol = 10'(col); pdat = 10'(dat);
    model(sof, row, col, dat);
    @(negedge clk);
    pv = 0; psof = 0;
  endtask

  task automatic rd(int a, output int v);
    raddr = 8'(a); #1; v = int'(rdata);
    @(negedge clk);
  endtask

  task automatic check_bins(string tag);
    repeat (3) @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      raddr = 8'(a); #0.01;
      chk(tag, int'(rdata), ref_m[a]);
    end
    @(negedge clk);
  endtask

  task automatic rand_frame(int n, int cmax);
    for (int i = 0; i < n; i++)
      pix(i == 0, int'($urandom % cmax), int'($urandom % cmax), int'($urandom % 1024));
  endtask

  task automatic full_regions();
    for (int r = 0; r < 4; r++) begin
      wr(2 + 2*r, 32'h03ff_0000);
      wr(3 + 2*r, 32'h03ff_0000);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 10; i++) begin sh[i] = 0; act[i] = 0; end
    for (int i = 0; i < 256; i++) ref_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    check_bins("R1 bins");

    // R3 R8: one region, 256 bins, unity gain
    full_regions();
    wr(1, 32'h2020_2020);
    wr(0, ctrl(1, 0, 3, 0));
    pix(1, 0, 0, 0);
    pix(0, 1, 1, 1023);
    for (int i = 0; i < 5; i++) pix(0, i, i, 100);
    chk("R11 busy on", int'(busy), 1);
    check_bins("R3 R8 burst");
    rd(25, v);  chk("R8 five same-bin hits", v, 5);
    rd(255, v); chk("R3 top bin", v, 1);
    rd(0, v);   chk("R3 bottom bin", v, 1);

    // R4 R5 R2: four overlapping regions, 256 requested -> 64
    wr(0, ctrl(1, 0, 3, 3));
    pix(1, 5, 5, 1023);
    pix(0, 6, 6, 0);
    check_bins("R4 R5 R2 clamp");
    rd(63, v);  chk("R4 R5 region0 bin63", v, 1);
    rd(127, v); chk("R5 region1 bin63", v, 1);
    rd(255, v); chk("R5 region3 bin63", v, 1);
    rd(192, v); chk("R2 region3 bin0", v, 1);

    // R6 Bayer gains incl. saturation of scaled value
    wr(0, ctrl(1, 0, 3, 0));
    wr(1, 32'hff_40_10_20);
    rand_frame(200, 64);
    check_bins("R6 bayer gains");

    // R7 three-channel mode, gain 3 ignored
    wr(1, 32'hff_10_40_20);
    wr(0, ctrl(1, 1, 3, 0));
    pix(1, 0, 3, 100);
    pix(0, 0, 4, 100);
    pix(0, 0, 5, 100);
    check_bins("R7 tri mode");
    rd(25, v); chk("R7 col mod 3 = 0", v, 1);
    rd(50, v); chk("R7 col mod 3 = 1", v, 1);
    rd(12, v); chk("R7 col mod 3 = 2", v, 1);

    // R9 saturation
    wr(1, 32'h2020_2020);
    wr(0, ctrl(1, 0, 3, 0));
    for (int i = 0; i < 300; i++) pix(i == 0, 2, 2, 40);
    check_bins("R9 saturate");
    rd(10, v); chk("R9 counter ceiling", v, CMAX);

    // R10 mid-frame write deferred
    wr(1, 32'h2020_2020);
    wr(0, ctrl(1, 0, 2, 1));
    pix(1, 0, 0, 400);
    wr(1, 32'h4040_4040);
    wr(0, ctrl(1, 0, 0, 0));
    pix(0, 0, 0, 400);
    check_bins("R10 deferred cfg");
    rd(50, v); chk("R10 old gain and bins kept", v, 2);
    pix(1, 0, 0, 400);
    check_bins("R10 applied at frame start");
    rd(25, v); chk("R10 new cfg applied", v, 1);

    // R11 disabled frame leaves bins
    wr(0, ctrl(0, 0, 3, 0));
    rand_frame(50, 64);
    chk("R11 busy off", int'(busy), 0);
    check_bins("R11 disabled frame");
    rd(25, v); chk("R11 bins preserved", v, 1);

    // random configurations
    for (int f = 0; f < 16; f++) begin
      wr(1, $urandom);
      for (int r = 0; r < 4; r++) begin
        wr(2 + 2*r, 32'(($urandom % 64) | (($urandom % 64) << 16)));
        wr(3 + 2*r, 32'(($urandom % 64) | (($urandom % 64) << 16)));
      end
      wr(0, ctrl(1, int'($urandom % 2), int'($urandom % 4), int'($urandom % 4)));
      rand_frame(150, 64);
      chk("R11 busy random", int'(busy), busy_exp);
      check_bins("R2 R3 R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule